// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with No-Reboot Strap

This block is a system watchdog that sits behind a simple strobe-based register bus. A down-counter is loaded from a programmable 10-bit limit and moves on each cycle in which the tick input is high. The first expiry that software fails to prevent sets a status flag and, when enabled, sends a one-cycle management interrupt pulse. The counter then reloads itself and runs again. If software still has not written the reload register when it expires a second time, the block issues a one-cycle system reset request. A no-reboot control can suppress that request.

The no-reboot control depends on a strap pin. The strap is captured while reset is held. A high strap pins no-reboot to 1 until the next reset. A low strap leaves no-reboot under software control. Four word registers are decoded from address bits [4:2] of a 32-byte window, and address bits [1:0] are ignored:

| Index | Register | Read | Write |
|---|---|---|---|
| 0 | count/reload | current count | any write reloads the counter |
| 1 | limit | limit value | bits [9:0] set the limit |
| 2 | status | bit0 first-expiry flag, bit1 second-expiry flag | write 1 to clear a bit |
| 3 | control | bit0 interrupt enable, bit1 no-reboot, bit2 latched strap (read-only) | bits [1:0] as read |

Top module: `wdog_two_stage`

## Requirements
- R1: While reset is high, and after it is released, the count and limit equal the DEF_LIMIT parameter. The status bits and the interrupt enable are 0. irq_o and sys_rst_o are low. No-reboot equals the strap level.
- R2: A cycle with tick_i high and no reload write does one of two things. If the count is above 1, the count decreases by 1. If the count is 1, this is an expiry: the count reloads from the limit. A limit of 0 is treated as 1.
- R3: A write to index 0 sets the count to the limit (or 1 if the limit is 0) at the next edge. That write has priority over a tick in the same cycle. It also cancels the second stage, so the next expiry is treated as a first expiry.
- R4: A first-stage expiry sets status bit0. If control bit0 is 1, irq_o goes high for exactly the next cycle. This applies to every expiry.
- R5: An expiry after a first expiry with no reload in between sets status bit1. If no-reboot is 0, sys_rst_o goes high for exactly one cycle after that expiry. At the edge after that pulse, both status bits and the second stage are cleared.
- R6: When no-reboot is 1, a second-stage expiry sets status bit1 and never pulses sys_rst_o. Later expiries stay in the second stage until a reload.
- R7: If strap_i is high during reset, control bit1 reads 1 and writes cannot clear it. If strap_i is low, writes set and clear bit1 freely. Control bit2 shows the latched strap.
- R8: Status bits are cleared by writing 1 to them, and writing 0 leaves them unchanged. A set caused by an expiry wins over a clear in the same cycle.
- R9: Read data appears on rdata_o one cycle after the rd_en_i strobe and holds until the next read. Indexes 4 to 7 read as 0.
- R10: The limit stores only 10 bits, so the largest limit is 0x3FF. A reload to 0x3FF reads back 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | No-reboot strap, sampled during reset |
| tick_i | input | 1 | Prescaler tick that advances the counter |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 5 | Byte address within the window |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | One-cycle management interrupt pulse |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume strap_i is steady throughout reset. They also assume the limit register is never written with a value that leaves the count at zero. Clamping zero to one removes that case, so the count-never-zero property depends only on that clamp. The bench drives bus strobes for exactly one cycle and raises tick_i only while no reset is pending. It changes strap_i only while reset is held, and covers both strap levels by repeating the reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    REG_COUNT = 3'd0,
    REG_LIMIT = 3'd1,
    REG_STAT  = 3'd2,
    REG_CTRL  = 3'd3
  } reg_sel_e;

  localparam int BIT_STS1  = 0;
  localparam int BIT_STS2  = 1;
  localparam int BIT_IEN   = 0;
  localparam int BIT_NOREB = 1;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TW        = 10,
  parameter int DEF_LIMIT = 1023
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          reload,
  input  logic [TW-1:0] limit,
  output logic [TW-1:0] cnt,
  output logic          expire
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] load_v;

  assign load_v = (limit == '0) ? ONE : limit;
  assign expire = tick & ~reload & (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= TW'(DEF_LIMIT);
    else if (reload) cnt <= load_v;
    else if (tick)   cnt <= (cnt <= ONE) ? load_v : cnt - ONE;
  end

  assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);
  assert_reload_loads_R3: assert property (@(posedge clk) disable iff (rst)
    reload |=> cnt == $past(load_v));
endmodule

// File: rtl/wdt_noreboot.sv
module wdt_noreboot (
  input  logic clk,
  input  logic rst,
  input  logic strap,
  input  logic wr,
  input  logic wbit,
  output logic noreb,
  output logic strap_lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_lat <= strap;
      noreb     <= strap;
    end else if (wr) begin
      noreb     <= wbit | strap_lat;
    end
  end

  assert_strap_pins_noreb_R7: assert property (@(posedge clk) disable iff (rst)
    strap_lat |-> noreb);
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic reload,
  input  logic ien,
  input  logic noreb,
  input  logic clr1,
  input  logic clr2,
  output logic sts1,
  output logic sts2,
  output logic irq,
  output logic rst_req
);
  logic armed, armed_eff, hit1, hit2;

  assign armed_eff = armed & ~rst_req;
  assign hit2      = expire & armed_eff;
  assign hit1      = expire & ~armed_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts1 <= 1'b0; sts2 <= 1'b0; armed <= 1'b0;
      irq <= 1'b0; rst_req <= 1'b0;
    end else begin
      if (hit1)                    sts1 <= 1'b1;
      else if (rst_req || clr1)    sts1 <= 1'b0;
      if (hit2)                    sts2 <= 1'b1;
      else if (rst_req || clr2)    sts2 <= 1'b0;
      if (reload)                  armed <= 1'b0;
      else if (hit1)               armed <= 1'b1;
      else if (rst_req)            armed <= 1'b0;
      irq     <= expire & ien;
      rst_req <= hit2 & ~noreb;
    end
  end

  assert_rst_single_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  assert_sts2_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !sts2);
  assert_noreb_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(noreb));
  assert_irq_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int TW        = 10,
  parameter int DW        = 16,
  parameter int DEF_LIMIT = 1023
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       strap_i,
  input  logic                       tick_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [wdt_pkg::ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  output logic                       irq_o,
  output logic                       sys_rst_o
);
  import wdt_pkg::*;

  reg_sel_e      sel;
  logic          wr_cnt, wr_lim, wr_sts, wr_ctl;
  logic [TW-1:0] limit, cnt;
  logic          ien, noreb, strap_lat, expire, sts1, sts2;
  logic [DW-1:0] rd_mux;

  assign sel    = reg_sel_e'(addr_i[ADDR_W-1:2]);
  assign wr_cnt = wr_en_i && sel == REG_COUNT;
  assign wr_lim = wr_en_i && sel == REG_LIMIT;
  assign wr_sts = wr_en_i && sel == REG_STAT;
  assign wr_ctl = wr_en_i && sel == REG_CTRL;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= TW'(DEF_LIMIT);
      ien   <= 1'b0;
    end else begin
      if (wr_lim) limit <= wdata_i[TW-1:0];
      if (wr_ctl) ien   <= wdata_i[BIT_IEN];
    end
  end

  wdt_counter #(.TW(TW), .DEF_LIMIT(DEF_LIMIT)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .reload(wr_cnt),
    .limit(limit), .cnt(cnt), .expire(expire));

  wdt_noreboot u_nr (
    .clk(clk), .rst(rst), .strap(strap_i), .wr(wr_ctl),
    .wbit(wdata_i[BIT_NOREB]), .noreb(noreb), .strap_lat(strap_lat));

  wdt_stage u_stg (
    .clk(clk), .rst(rst), .expire(expire), .reload(wr_cnt),
    .ien(ien), .noreb(noreb),
    .clr1(wr_sts & wdata_i[BIT_STS1]), .clr2(wr_sts & wdata_i[BIT_STS2]),
    .sts1(sts1), .sts2(sts2), .irq(irq_o), .rst_req(sys_rst_o));

  always_comb begin
    case (sel)
      REG_COUNT: rd_mux = DW'(cnt);
      REG_LIMIT: rd_mux = DW'(limit);
      REG_STAT:  rd_mux = DW'({sts2, sts1});
      REG_CTRL:  rd_mux = DW'({strap_lat, noreb, ien});
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en_i) |-> $stable(rdata_o));
endmodule

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEF = 20;

  logic clk = 0, rst = 1, strap = 0, tick = 0, wr = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, srst;

  int checks = 0, fails = 0, n_irq = 0, n_rst = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_stage #(.TW(10), .DW(16), .DEF_LIMIT(DEF)) u_wdog_two_stage (
    .clk(clk), .rst(rst), .strap_i(strap), .tick_i(tick), .wr_en_i(wr),
    .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .sys_rst_o(srst));

  // behavioural reference
  int m_cnt, m_lim, m_ien, m_nr, m_strap, m_s1, m_s2, m_arm, m_irq, m_rst, m_rd;
  always @(posedge clk) begin
    int lv, ex, sec, fst, idx, rv;
    if (rst) begin
      m_cnt = DEF; m_lim = DEF; m_ien = 0; m_nr = strap; m_strap = strap;
      m_s1 = 0; m_s2 = 0; m_arm = 0; m_irq = 0; m_rst = 0; m_rd = 0;
    end else begin
      idx = addr / 4;
      lv  = (m_lim == 0) ? 1 : m_lim;
      ex  = (tick && !(wr && idx == 0) && m_cnt <= 1) ? 1 : 0;
      sec = (ex && m_arm && !m_rst) ? 1 : 0;
      fst = (ex && !sec) ? 1 : 0;
      if (rd) begin
        case (idx)
          0: rv = m_cnt;
          1: rv = m_lim;
          2: rv = m_s1 + 2 * m_s2;
          3: rv = m_ien + 2 * m_nr + 4 * m_strap;
          default: rv = 0;
        endcase
        m_rd = rv;
      end
      if (m_rst) begin m_s1 = 0; m_s2 = 0; m_arm = 0; end
      if (wr && idx == 2) begin
        if (wdata[0]) m_s1 = 0;
        if (wdata[1]) m_s2 = 0;
      end
      if (fst) begin m_s1 = 1; m_arm = 1; end
      if (sec) m_s2 = 1;
      m_rst = (sec && !m_nr) ? 1 : 0;
      m_irq = (ex && m_ien) ? 1 : 0;
      if (wr && idx == 0) begin m_cnt = lv; m_arm = 0; end
      else if (tick) m_cnt = (m_cnt <= 1) ? lv : m_cnt - 1;
      if (wr && idx == 1) m_lim = wdata & 16'h3FF;
      if (wr && idx == 3) begin m_ien = wdata[0]; m_nr = wdata[1] | m_strap; end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "irq_o", irq, m_irq);
      chk(cur_req, "sys_rst_o", srst, m_rst);
      chk(cur_req, "rdata_o", rdata, m_rd);
      n_irq += irq;
      n_rst += srst;
    end
  end

  task automatic bus_wr(input int a, input int d);
    @(negedge clk); wr = 1; addr = 5'(a); wdata = 16'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input int a, output int d);
    @(negedge clk); rd = 1; addr = 5'(a);
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic run_ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst = 1; strap = s;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    fails++; checks++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    summary();
  end

  initial begin
    int v, i0, r0;
    do_reset(0);
    cur_req = "R1";
    chk("R1", "irq idle", irq, 0);
    chk("R1", "rst idle", srst, 0);
    bus_rd(0, v);  chk("R1", "count", v, DEF);
    bus_rd(4, v);  chk("R1", "limit", v, DEF);
    bus_rd(8, v);  chk("R1", "status", v, 0);
    bus_rd(12, v); chk("R7", "ctrl strap low", v, 0);
    bus_rd(16, v); chk("R9", "unmapped", v, 0);

    cur_req = "R5";
    bus_wr(4, 3); bus_wr(12, 1); bus_wr(0, 0);
    i0 = n_irq; r0 = n_rst;
    run_ticks(12); repeat (2) @(negedge clk);
    chk("R4", "irq count", n_irq - i0, 4);
    chk("R5", "reset pulses", n_rst - r0, 2);
    bus_rd(8, v); chk("R5", "status cleared after pulse", v, 0);

    cur_req = "R3";
    bus_wr(0, 0);
    i0 = n_irq; r0 = n_rst;
    for (int k = 0; k < 5; k++) begin run_ticks(2); bus_wr(0, 0); end
    chk("R3", "no irq with reloads", n_irq - i0, 0);
    run_ticks(3); repeat (2) @(negedge clk);
    chk("R4", "first expiry irq", n_irq - i0, 1);
    bus_rd(8, v); chk("R4", "status bit0", v, 1);
    bus_wr(0, 0); run_ticks(3); repeat (2) @(negedge clk);
    chk("R3", "reload cancels second stage", n_rst - r0, 0);
    bus_rd(8, v); chk("R3", "still first stage", v, 1);

    cur_req = "R8";
    bus_wr(8, 2); bus_rd(8, v); chk("R8", "write0 keeps bit0", v, 1);
    bus_wr(8, 1); bus_rd(8, v); chk("R8", "w1c bit0", v, 0);

    cur_req = "R6";
    bus_wr(12, 3); bus_wr(0, 0);
    i0 = n_irq; r0 = n_rst;
    run_ticks(9); repeat (2) @(negedge clk);
    chk("R6", "no reset", n_rst - r0, 0);
    chk("R6", "irq each expiry", n_irq - i0, 3);
    bus_rd(8, v); chk("R6", "both status", v, 3);
    cur_req = "R7";
    bus_wr(12, 1); bus_rd(12, v); chk("R7", "noreb cleared strap low", v, 1);
    bus_wr(8, 3);

    cur_req = "R2";
    bus_wr(12, 3); bus_wr(4, 0); bus_wr(0, 0);
    bus_rd(0, v); chk("R2", "zero limit loads 1", v, 1);
    i0 = n_irq;
    run_ticks(4); repeat (2) @(negedge clk);
    chk("R2", "expiry every tick", n_irq - i0, 4);

    cur_req = "R10";
    bus_wr(4, 16'h7FF); bus_rd(4, v); chk("R10", "limit 10 bits", v, 16'h3FF);
    bus_wr(0, 0); bus_rd(0, v); chk("R10", "max count", v, 16'h3FF);
    run_ticks(5); bus_rd(0, v); chk("R2", "decrement", v, 16'h3FA);

    cur_req = "R7";
    do_reset(1);
    bus_rd(12, v); chk("R7", "strap high ctrl", v, 6);
    bus_wr(12, 1); bus_rd(12, v); chk("R7", "noreb locked", v, 7);
    bus_wr(4, 2); bus_wr(0, 0);
    i0 = n_irq; r0 = n_rst;
    run_ticks(6); repeat (2) @(negedge clk);
    chk("R7", "strap blocks reset", n_rst - r0, 0);
    chk("R4", "irq strap run", n_irq - i0, 3);

    done = 1;
    summary();
  end
endmodule